// File: doc/BRIEF.md
# External Memory DMA Channel with Single-Address Transfers

This block is one DMA channel that moves data between external memory and an external peripheral. Software programs a source address, a destination address, a transfer count and a mode word through a small register-style configuration port. Once enabled, the channel waits for the peripheral to raise its request. For each request it then runs one transfer on a simple external bus master port. The port carries an address, a read strobe, a write strobe, byte enables and a data path.

Two transfer modes are supported.

- **Single-address mode.** One bus cycle drives the memory address and pulls an active-low acknowledge to the peripheral at the same time. Data therefore passes straight between memory and the peripheral without going through the channel. A direction bit decides whether memory is read (peripheral receives) or written (peripheral supplies).
- **Dual-address mode.** The channel reads a word from the source address into a holding register. It then writes that word to the destination address in the next clock.

After each transfer, the address registers in use are stepped and the count is decremented. On the last transfer the channel can pulse a one-cycle end-of-transfer strobe, after which it disables itself.

Top module: `xdma_chan`

## Requirements
- R1: In single-address mode each transfer is exactly one clock long. In that clock `ack_n` is 0 and the memory address is on `bus_addr`. In the following clock both strobes and `ack_n` return to idle (`bus_rd`=0, `bus_wr`=0, `ack_n`=1).
- R2: Mode word bit 2 is the direction bit.
  - Direction 0 (peripheral is the destination): the single-address cycle drives the source register on `bus_addr` with `bus_rd`=1 and `bus_wr`=0.
  - Direction 1 (peripheral is the source): the cycle drives the destination register with `bus_wr`=1 and `bus_rd`=0.
  - `bus_rd` and `bus_wr` are never both 1.
- R3: In single-address mode, the address register not selected by the direction bit never appears on `bus_addr` and is never stepped. Its readback is unchanged after the transfers.
- R4: `ack_n` is 0 only during a single-address bus cycle. It needs no separate enable. It stays 1 throughout dual-address transfers.
- R5: `tend` is 1 only when mode bit 3 (end strobe enable) is 1, and then only in the final bus cycle of the last transfer. That is the single-address cycle, or the write cycle in dual-address mode. It is 0 in every other clock.
- R6: Dual-address mode is selected by mode bit 1 = 0. Each transfer is a one-clock read at the source address (`bus_rd`=1), followed in the next clock by a one-clock write at the destination address (`bus_wr`=1). The write drives on `bus_wdata` the `bus_rdata` value sampled at the end of the read clock.
- R7: The count register (register 2) decrements by one per completed transfer.
  - When the last transfer completes, the enable bit (mode bit 0) clears and the done flag (status bit 1) sets.
  - If the channel is enabled with a count of 0, it clears its enable and sets done one clock later without any bus cycle.
- R8: Transfer size and address stepping are set by the mode word.
  - Size field, mode bits 9:8: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
  - Step codes: source in bits 5:4, destination in bits 7:6. Code 1 increments the used register by the size, code 2 decrements it, and codes 0 and 3 hold it.
  - `bus_be` during a bus cycle is 1 shifted left by address bits 1:0 for size 1, 3 shifted left by 2×address bit 1 for size 2, and all ones for size 4. It is 0 when idle.
- R9: A transfer starts only in an idle clock where the channel is enabled and `req` is 1 at the clock edge. No transfer starts in a clock in which a configuration write is accepted.
- R10: Configuration registers are written by a clock with `cfg_we`=1 at address 0 (source), 1 (destination), 2 (count) or 3 (mode).
  - These writes are ignored while a bus cycle is in progress.
  - Status at address 4 reads bit 0 = busy (bus cycle in progress) and bit 1 = done.
  - A write to the mode register clears done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback for `cfg_addr` |
| req | input | 1 | Transfer request from the peripheral |
| bus_addr | output | AW | Memory address of the current bus cycle |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |
| bus_be | output | DW/8 | Byte enables of the current bus cycle |
| bus_wdata | output | DW | Write data in dual-address write cycles |
| bus_rdata | input | DW | Read data sampled at the end of dual-address read cycles |
| ack_n | output | 1 | Active-low peripheral acknowledge |
| tend | output | 1 | End-of-transfer strobe on the final bus cycle |

## Verification
The bench aims at the direction-dependent register choice in single-address mode. A design that mixed them up would drive the unused register's address, or step it, which shows up as a wrong `bus_addr` or a changed readback.

It also checks:
- that `tend` appears only on the last transfer and only when enabled; a design with an off-by-one count compare would pulse it one transfer early or never;
- decrementing addresses and the byte-enable pattern at every size;
- a count of zero at enable time, where a naive design would wrap the count and run thousands of cycles;
- configuration writes landing mid-cycle or in the same clock as a request, where a design without the busy guard would corrupt the count or start a transfer on stale settings.

// File: rtl/xdma_chan.sv
module xdma_chan #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          req,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW/8-1:0] bus_be,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          ack_n,
  output logic          tend
);
  localparam int BEW = DW / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_SGL, ST_RD, ST_WR} st_t;
  st_t st;

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic en_q, sgl_q, dir_q, tde_q, done_q;
  logic [1:0] sstep_q, dstep_q, sz_q;

  wire idle    = (st == ST_IDLE);
  wire cfg_ok  = cfg_we && idle;
  wire cnt_nz  = (cnt_q != '0);
  wire start   = idle && !cfg_we && en_q && req && cnt_nz;
  wire zstop   = idle && !cfg_we && en_q && !cnt_nz;
  wire fin     = (st == ST_SGL) || (st == ST_WR);
  wire last    = (cnt_q == CW'(1));
  wire upd_src = fin && (!sgl_q || !dir_q);
  wire upd_dst = fin && (!sgl_q || dir_q);

  logic [AW-1:0] nb;
  always_comb begin
    case (sz_q)
      2'd0:    nb = AW'(1);
      2'd1:    nb = AW'(2);
      default: nb = AW'(4);
    endcase
  end

  function automatic logic [AW-1:0] step_a(input logic [AW-1:0] a, input logic [1:0] c,
                                           input logic [AW-1:0] n);
    case (c)
      2'd1:    return a + n;
      2'd2:    return a - n;
      default: return a;
    endcase
  endfunction

  function automatic logic [BEW-1:0] be_of(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      2'd0:    return BEW'(1) << lo;
      2'd1:    return BEW'(3) << {lo[1], 1'b0};
      default: return BEW'(4'hF);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      en_q    <= 1'b0;
      sgl_q   <= 1'b0;
      dir_q   <= 1'b0;
      tde_q   <= 1'b0;
      done_q  <= 1'b0;
      sstep_q <= 2'd0;
      dstep_q <= 2'd0;
      sz_q    <= 2'd0;
    end else begin
      if (cfg_ok) begin
        case (cfg_addr)
          3'd0: src_q <= cfg_wdata[AW-1:0];
          3'd1: dst_q <= cfg_wdata[AW-1:0];
          3'd2: cnt_q <= cfg_wdata[CW-1:0];
          3'd3: begin
            en_q    <= cfg_wdata[0];
            sgl_q   <= cfg_wdata[1];
            dir_q   <= cfg_wdata[2];
            tde_q   <= cfg_wdata[3];
            sstep_q <= cfg_wdata[5:4];
            dstep_q <= cfg_wdata[7:6];
            sz_q    <= cfg_wdata[9:8];
            done_q  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (zstop) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
      end
      case (st)
        ST_IDLE: if (start) st <= sgl_q ? ST_SGL : ST_RD;
        ST_RD: begin
          data_q <= bus_rdata;
          st     <= ST_WR;
        end
        default: st <= ST_IDLE;
      endcase
      if (fin) begin
        cnt_q <= cnt_q - CW'(1);
        if (last) begin
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (upd_src) src_q <= step_a(src_q, sstep_q, nb);
      if (upd_dst) dst_q <= step_a(dst_q, dstep_q, nb);
    end
  end

  always_comb begin
    case (st)
      ST_SGL:  bus_addr = dir_q ? dst_q : src_q;
      ST_RD:   bus_addr = src_q;
      ST_WR:   bus_addr = dst_q;
      default: bus_addr = '0;
    endcase
  end

  assign bus_rd    = (st == ST_RD) || ((st == ST_SGL) && !dir_q);
  assign bus_wr    = (st == ST_WR) || ((st == ST_SGL) && dir_q);
  assign bus_be    = idle ? '0 : be_of(bus_addr[1:0], sz_q);
  assign bus_wdata = (st == ST_WR) ? data_q : '0;
  assign ack_n     = (st != ST_SGL);
  assign tend      = tde_q && last && fin;

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = 32'(src_q);
      3'd1:    cfg_rdata = 32'(dst_q);
      3'd2:    cfg_rdata = 32'(cnt_q);
      3'd3:    cfg_rdata = {22'd0, sz_q, dstep_q, sstep_q, tde_q, dir_q, sgl_q, en_q};
      3'd4:    cfg_rdata = {30'd0, done_q, !idle};
      default: cfg_rdata = '0;
    endcase
  end

  p_ack_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);
  p_back_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || (bus_rd && !ack_n)) |=> !(bus_rd || bus_wr));
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  p_ack_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (bus_rd || bus_wr));
  p_tend_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tend |-> (tde_q && (bus_rd || bus_wr)));
  p_dual_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ack_n) |=> (bus_wr && ack_n));
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != $past(cnt_q)) && !$past(cfg_ok)) |-> (cnt_q == $past(cnt_q) - CW'(1)));
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cfg_we && cfg_addr == 3'd2 && !fin) |=> $stable(cnt_q));
endmodule

// File: tb/xdma_chan_tb.sv
module xdma_chan_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic req = 1'b0;
  logic [31:0] bus_addr;
  logic bus_rd, bus_wr, ack_n, tend;
  logic [3:0] bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  int total = 0;
  int bad = 0;

  // model state
  logic [31:0] m_src, m_dst;
  int m_cnt;
  logic m_sgl, m_dir, m_tde;
  logic [1:0] m_ss, m_ds, m_sz;

  xdma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_n(ack_n), .tend(tend)
  );

  always #5 clk = ~clk;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] stp(input logic [31:0] a, input logic [1:0] c, input logic [1:0] sz);
    logic [31:0] n;
    n = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
    if (c == 2'd1) return a + n;
    if (c == 2'd2) return a - n;
    return a;
  endfunction

  function automatic logic [3:0] ebe(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd0) return 4'b0001 << a[1:0];
    if (sz == 2'd1) return 4'b0011 << {a[1], 1'b0};
    return 4'b1111;
  endfunction

  function automatic logic [31:0] mword(input logic en);
    return {22'd0, m_sz, m_ds, m_ss, m_tde, m_dir, m_sgl, en};
  endfunction

  task automatic wcfg(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rcfg(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int c);
    m_src = s; m_dst = d; m_cnt = c;
    wcfg(3'd0, s); wcfg(3'd1, d); wcfg(3'd2, 32'(c)); wcfg(3'd3, mword(1'b1));
  endtask

  // one transfer, starting at a negedge with the channel idle
  task automatic xfer;
    logic [31:0] rv;
    logic etend;
    etend = m_tde && (m_cnt == 1);
    req = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    if (m_sgl) begin
      chk("R1 ack low in single cycle", 64'(ack_n), 64'(0));
      chk("R2 address by direction", 64'(bus_addr), 64'(m_dir ? m_dst : m_src));
      chk("R2 read strobe", 64'(bus_rd), 64'(!m_dir));
      chk("R2 write strobe", 64'(bus_wr), 64'(m_dir));
      chk("R8 byte enables", 64'(bus_be), 64'(ebe(m_dir ? m_dst : m_src, m_sz)));
      chk("R5 end strobe", 64'(tend), 64'(etend));
      if (m_dir) m_dst = stp(m_dst, m_ds, m_sz);
      else       m_src = stp(m_src, m_ss, m_sz);
    end else begin
      rv = $urandom;
      bus_rdata = rv;
      chk("R6 read at source", 64'(bus_addr), 64'(m_src));
      chk("R6 read strobe", 64'({bus_rd, bus_wr}), 64'(2'b10));
      chk("R4 ack idle in dual", 64'(ack_n), 64'(1));
      chk("R5 no end strobe on read", 64'(tend), 64'(0));
      chk("R8 byte enables read", 64'(bus_be), 64'(ebe(m_src, m_sz)));
      @(posedge clk); @(negedge clk);
      bus_rdata = ~rv;
      chk("R6 write at destination", 64'(bus_addr), 64'(m_dst));
      chk("R6 write strobe", 64'({bus_rd, bus_wr}), 64'(2'b01));
      chk("R6 write data", 64'(bus_wdata), 64'(rv));
      chk("R4 ack idle in dual write", 64'(ack_n), 64'(1));
      chk("R5 end strobe", 64'(tend), 64'(etend));
      m_src = stp(m_src, m_ss, m_sz);
      m_dst = stp(m_dst, m_ds, m_sz);
    end
    m_cnt--;
    @(posedge clk); @(negedge clk);
    chk("R1 back to idle", 64'({bus_rd, bus_wr, ack_n, tend}), 64'(4'b0010));
  endtask

  task automatic check_end;
    logic [31:0] v;
    rcfg(3'd4, v); chk("R7 done set, R10 not busy", 64'(v), 64'(2));
    rcfg(3'd3, v); chk("R7 enable cleared", 64'(v), 64'(mword(1'b0)));
    rcfg(3'd2, v); chk("R7 count zero", 64'(v), 64'(0));
    rcfg(3'd0, v); chk("R3 source readback", 64'(v), 64'(m_src));
    rcfg(3'd1, v); chk("R3 destination readback", 64'(v), 64'(m_dst));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rcfg(3'd4, v); chk("R10 reset status", 64'(v), 64'(0));
    chk("R4 reset outputs", 64'({bus_rd, bus_wr, ack_n, tend}), 64'(4'b0010));

    // R3: direction 0, destination has increment but must stay put
    m_sgl = 1; m_dir = 0; m_tde = 1; m_ss = 2'd1; m_ds = 2'd1; m_sz = 2'd0;
    setup(32'h1000_0003, 32'h2000_0000, 3);
    // R9: request low, enabled -> nothing happens
    @(posedge clk); @(negedge clk);
    chk("R9 no request no cycle", 64'({bus_rd, bus_wr, ack_n}), 64'(3'b001));
    for (int i = 0; i < 3; i++) xfer();
    check_end();

    // R2/R8: direction 1, decrementing destination, 2-byte size
    m_dir = 1; m_ds = 2'd2; m_ss = 2'd2; m_sz = 2'd1; m_tde = 0;
    setup(32'h3000_0000, 32'h4000_0006, 2);
    for (int i = 0; i < 2; i++) xfer();
    check_end();

    // R10: write during a bus cycle is ignored, busy visible
    m_dir = 0; m_ss = 2'd0; m_sz = 2'd2; m_tde = 1;
    setup(32'h5000_0010, 32'h6000_0000, 3);
    req = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    rcfg(3'd4, v); chk("R10 busy during cycle", 64'(v), 64'(1));
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 32'h77;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    m_cnt = 2;
    rcfg(3'd2, v); chk("R10 count write ignored while busy", 64'(v), 64'(2));
    // R9: config write in same clock as request blocks start
    req = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = m_src;
    @(posedge clk); @(negedge clk);
    req = 1'b0; cfg_we = 1'b0;
    chk("R9 no start with config write", 64'({bus_rd, bus_wr, ack_n}), 64'(3'b001));
    for (int i = 0; i < 2; i++) xfer();
    check_end();

    // R7: enable with count zero
    m_sgl = 0;
    setup(32'h0, 32'h0, 0);
    req = 1'b1;
    chk("R7 zero count no cycle", 64'({bus_rd, bus_wr, ack_n}), 64'(3'b001));
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    chk("R7 zero count still idle", 64'({bus_rd, bus_wr, ack_n}), 64'(3'b001));
    check_end();
    wcfg(3'd3, mword(1'b0));
    rcfg(3'd4, v); chk("R10 mode write clears done", 64'(v), 64'(0));

    // random mix of both modes
    for (int r = 0; r < 24; r++) begin
      m_sgl = 1'($urandom); m_dir = 1'($urandom); m_tde = 1'($urandom);
      m_ss = 2'($urandom); m_ds = 2'($urandom); m_sz = 2'($urandom);
      setup($urandom, $urandom, 1 + int'($urandom % 5));
      while (m_cnt > 0) begin
        if ($urandom % 3 == 0) begin
          @(posedge clk); @(negedge clk);
        end
        xfer();
      end
      check_end();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule